// File: doc/BRIEF.md
# Successive-Approximation Offset Calibrator for Two Compensation DACs

This block gives two residue-amplifier offset compensation DACs a fast start-up value before a slow tracking loop takes over. A start pulse begins a calibration run. The block raises a control that ties the amplifier inputs together, so that the amplifier output carries only its own offset. It then resolves each 9-bit DAC code by binary search, from the most significant bit down to the least significant bit. The decision for each bit comes from an external comparator that reports whether the compensated output is still above zero.

Each bit trial lasts a fixed window of eight clocks, which gives the analog path time to settle. The comparator is sampled only on the last clock of the window. DAC 0 is resolved first and DAC 1 second, which takes 144 clocks in all. When the run ends, the input-short control is released, a one-cycle done pulse is raised, and both final codes stay on the outputs for the background loop to pick up. A select output tells the external comparator path which DAC is under trial.

Top module: `offset_sar_cal`

## Requirements
- R1: While reset is asserted and after reset is released, both codes are 0, `short_o` is 0, `done_o` is 0 and `cal_sel_o` is 0.
- R2: A start pulse that is sampled while the block is idle begins a run in the next cycle. In that cycle `short_o` is 1, DAC 0's code (`dac_codes_o[8:0]`) is 9'b1_0000_0000, DAC 1's code (`dac_codes_o[17:9]`) is 0 and `cal_sel_o` is 0.
- R3: Each bit trial lasts exactly 8 clocks. `cmp_pos_i` is sampled only on the eighth clock of the window, and its value on the other seven clocks has no effect on any code.
- R4: When the trial bit is decided, `cmp_pos_i`=1 keeps it at 1 and `cmp_pos_i`=0 clears it. In the same step the next lower bit is set to 1 as the new trial. Bits are decided from bit 8 down to bit 0, so the final code equals the largest code for which the comparator still reports 1.
- R5: DAC 0 is searched first. When bit 0 of DAC 0 is decided, DAC 1 loads 9'b1_0000_0000, `cal_sel_o` becomes 1, and DAC 0 then holds its final value.
- R6: `short_o` stays high for exactly 144 consecutive cycles of a run. It falls in the same cycle in which `done_o` rises.
- R7: `done_o` is a single-cycle pulse that follows the 144th run cycle. While it is high, both outputs already carry the final codes.
- R8: A start pulse during a run, or during the done cycle, is ignored. The run still ends after 144 cycles with the same codes, and no new run begins.
- R9: Outside a run, both codes hold their values regardless of `cmp_pos_i`, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a calibration run |
| cmp_pos_i | input | 1 | Comparator: compensated output still above zero |
| short_o | output | 1 | Ties the amplifier inputs together during a run |
| cal_sel_o | output | 1 | Index of the DAC under trial |
| dac_codes_o | output | 18 | DAC i code at bits [i*9 +: 9] |
| done_o | output | 1 | One-cycle pulse when both codes are final |

## Verification
The bound checker watches properties on every cycle. It checks that a run only begins after a start, that `short_o` is followed by either more shorting or the done pulse, and that done is one cycle long and coincides with the release of the short. It also checks that at most two code bits change per cycle during a run, and that codes are frozen outside a run. Only the bench scenarios can show that the search converges on the right code for a given offset. They also show that comparator values outside the sampling clock are ignored, that the eight-clock window and the 144-cycle run have the correct length, and that a start during a run leaves the result unchanged. To do this, the bench models the comparator against hidden target codes and drives inverted values on the clocks that should not be sampled.

// File: rtl/offset_sar_pkg.sv
package offset_sar_pkg;

  typedef enum logic [1:0] {
    CAL_IDLE = 2'd0,
    CAL_RUN  = 2'd1,
    CAL_DONE = 2'd2
  } cal_state_t;

endpackage

// File: rtl/sar_window_timer.sv
module sar_window_timer #(
  parameter int TRIAL_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic last_o
);
  localparam int CNT_W = (TRIAL_CLKS > 1) ? $clog2(TRIAL_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TRIAL_CLKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_last;

  assign at_last = (cnt_q == CNT_LAST);
  assign cnt_en  = restart_i | run_i;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i) begin
      cnt_d = '0;
    end else if (run_i) begin
      if (at_last) cnt_d = '0;
      else         cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = run_i & at_last;

endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int CODE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear_i,
  input  logic                      load_i,
  input  logic                      decide_i,
  input  logic [$clog2(CODE_W)-1:0] bit_idx_i,
  input  logic                      keep_i,
  output logic [CODE_W-1:0]         code_o
);
  localparam int BIT_W = $clog2(CODE_W);
  localparam logic [CODE_W-1:0] TRIAL_MSB = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;

  assign code_en = clear_i | load_i | decide_i;

  always_comb begin
    code_d = code_q;
    if (load_i) begin
      code_d = TRIAL_MSB;
    end else if (clear_i) begin
      code_d = '0;
    end else if (decide_i) begin
      for (int i = 0; i < CODE_W; i++) begin
        if (BIT_W'(i) == bit_idx_i) begin
          code_d[i] = keep_i;
        end
        if ((i + 1 < CODE_W) && (BIT_W'(i + 1) == bit_idx_i)) begin
          code_d[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

  assign code_o = code_q;

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import offset_sar_pkg::*;
#(
  parameter int N_DAC  = 2,
  parameter int CODE_W = 9
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       start_i,
  input  logic                                       last_i,
  output logic                                       accept_o,
  output logic                                       run_o,
  output logic                                       done_o,
  output logic                                       advance_o,
  output logic [((N_DAC > 1) ? $clog2(N_DAC) : 1)-1:0] sel_o,
  output logic [$clog2(CODE_W)-1:0]                   bit_o
);
  localparam int SEL_W = (N_DAC > 1) ? $clog2(N_DAC) : 1;
  localparam int BIT_W = $clog2(CODE_W);
  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(N_DAC - 1);
  localparam logic [BIT_W-1:0] BIT_TOP  = BIT_W'(CODE_W - 1);

  cal_state_t       st_q, st_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             lsb_step;
  logic             finish;

  assign lsb_step  = last_i & (bit_q == '0);
  assign finish    = lsb_step & (sel_q == SEL_LAST);
  assign advance_o = lsb_step & (sel_q != SEL_LAST);
  assign accept_o  = (st_q == CAL_IDLE) & start_i;

  always_comb begin
    st_d  = st_q;
    sel_d = sel_q;
    bit_d = bit_q;
    unique case (st_q)
      CAL_IDLE: begin
        if (start_i) begin
          st_d  = CAL_RUN;
          sel_d = '0;
          bit_d = BIT_TOP;
        end
      end
      CAL_RUN: begin
        if (finish) begin
          st_d = CAL_DONE;
        end else if (advance_o) begin
          sel_d = sel_q + 1'b1;
          bit_d = BIT_TOP;
        end else if (last_i) begin
          bit_d = bit_q - 1'b1;
        end
      end
      CAL_DONE: begin
        st_d = CAL_IDLE;
      end
      default: begin
        st_d = CAL_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CAL_IDLE;
      sel_q <= '0;
      bit_q <= '0;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
      bit_q <= bit_d;
    end
  end

  assign run_o  = (st_q == CAL_RUN);
  assign done_o = (st_q == CAL_DONE);
  assign sel_o  = sel_q;
  assign bit_o  = bit_q;

endmodule

// File: rtl/offset_sar_cal.sv
module offset_sar_cal #(
  parameter int N_DAC      = 2,
  parameter int CODE_W     = 9,
  parameter int TRIAL_CLKS = 8
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        start_i,
  input  logic                                        cmp_pos_i,
  output logic                                        short_o,
  output logic [((N_DAC > 1) ? $clog2(N_DAC) : 1)-1:0] cal_sel_o,
  output logic [N_DAC*CODE_W-1:0]                      dac_codes_o,
  output logic                                        done_o
);
  localparam int SEL_W = (N_DAC > 1) ? $clog2(N_DAC) : 1;
  localparam int BIT_W = $clog2(CODE_W);

  logic             accept;
  logic             run;
  logic             last_clk;
  logic             advance;
  logic [SEL_W-1:0] sel;
  logic [BIT_W-1:0] bit_idx;

  sar_sequencer #(
    .N_DAC  (N_DAC),
    .CODE_W (CODE_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .last_i    (last_clk),
    .accept_o  (accept),
    .run_o     (run),
    .done_o    (done_o),
    .advance_o (advance),
    .sel_o     (sel),
    .bit_o     (bit_idx)
  );

  sar_window_timer #(
    .TRIAL_CLKS (TRIAL_CLKS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (accept),
    .run_i     (run),
    .last_o    (last_clk)
  );

  for (genvar g = 0; g < N_DAC; g++) begin : g_dac
    logic load_g;
    logic clear_g;
    logic decide_g;

    if (g == 0) begin : g_first
      assign load_g  = accept;
      assign clear_g = 1'b0;
    end else begin : g_later
      assign load_g  = advance & (sel == SEL_W'(g - 1));
      assign clear_g = accept;
    end

    assign decide_g = last_clk & (sel == SEL_W'(g));

    sar_code_reg #(
      .CODE_W (CODE_W)
    ) u_code (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (clear_g),
      .load_i    (load_g),
      .decide_i  (decide_g),
      .bit_idx_i (bit_idx),
      .keep_i    (cmp_pos_i),
      .code_o    (dac_codes_o[g*CODE_W +: CODE_W])
    );
  end

  assign short_o   = run;
  assign cal_sel_o = sel;

endmodule

// File: rtl/offset_sar_cal_chk.sv
module offset_sar_cal_chk #(
  parameter int N_DAC  = 2,
  parameter int CODE_W = 9,
  parameter int SEL_W  = 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_i,
  input logic                    short_o,
  input logic                    done_o,
  input logic [SEL_W-1:0]        cal_sel_o,
  input logic [N_DAC*CODE_W-1:0] dac_codes_o
);

  // R2
  short_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_o) |-> $past(start_i));

  // R6
  short_ends_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_o |=> (short_o || done_o));

  // R6
  done_releases_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!short_o && $past(short_o)));

  // R7
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  no_restart_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !short_o);

  // R4
  few_bits_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (short_o && $past(short_o)) |-> ($countones(dac_codes_o ^ $past(dac_codes_o)) <= 2));

  // R9
  codes_frozen_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!short_o && !start_i) |=> $stable(dac_codes_o));

  // R5
  sel_never_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (short_o && $past(short_o)) |-> (cal_sel_o >= $past(cal_sel_o)));

endmodule

bind offset_sar_cal offset_sar_cal_chk #(
  .N_DAC  (N_DAC),
  .CODE_W (CODE_W),
  .SEL_W  (SEL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .short_o     (short_o),
  .done_o      (done_o),
  .cal_sel_o   (cal_sel_o),
  .dac_codes_o (dac_codes_o)
);

// File: tb/offset_sar_cal_bench.sv
`timescale 1ns/1ps
module offset_sar_cal_bench;
  localparam int W    = 9;
  localparam int WIN  = 8;
  localparam int PER  = W * WIN;
  localparam int RUNL = 2 * PER;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic         cmp_pos_i;
  logic         short_o;
  logic [0:0]   cal_sel_o;
  logic [2*W-1:0] dac_codes_o;
  logic         done_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] exp_code [2];
  logic [W-1:0] tgt [2];
  int unsigned  seed_sink;

  always #4 clk = ~clk;

  offset_sar_cal u_offset_sar_cal (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cmp_pos_i   (cmp_pos_i),
    .short_o     (short_o),
    .cal_sel_o   (cal_sel_o),
    .dac_codes_o (dac_codes_o),
    .done_o      (done_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit keep_bit(input logic [W-1:0] trial, input logic [W-1:0] target);
    return trial <= target;
  endfunction

  task automatic run_cal(input logic [W-1:0] ta, input logic [W-1:0] tb,
                         input bit noisy, input int mid_start_t);
    tgt[0] = ta;
    tgt[1] = tb;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    exp_code[0] = 9'h100;
    exp_code[1] = 9'h000;
    check(short_o == 1'b1 && dac_codes_o == {9'h000, 9'h100} && cal_sel_o == 1'b0,
          "R2", {13'd0, short_o, dac_codes_o}, {14'h1, 9'h000, 9'h100});
    for (int t = 0; t < RUNL; t++) begin
      int d, w, b;
      bit k;
      d = t / PER;
      w = (t % PER) % WIN;
      b = (W - 1) - (t % PER) / WIN;
      k = keep_bit(exp_code[d], tgt[d]);
      check(short_o == 1'b1, "R6", short_o, 1);
      check(done_o == 1'b0, "R7", done_o, 0);
      check(cal_sel_o == d[0], "R5", cal_sel_o, d);
      check(dac_codes_o == {exp_code[1], exp_code[0]}, "R4 R3",
            dac_codes_o, {exp_code[1], exp_code[0]});
      if (w == WIN - 1) cmp_pos_i = k;
      else if (noisy)   cmp_pos_i = ~k;
      else              cmp_pos_i = 1'($urandom_range(0, 1));
      start_i = (t == mid_start_t);
      @(negedge clk);
      start_i = 1'b0;
      if (w == WIN - 1) begin
        exp_code[d][b] = k;
        if (b > 0) exp_code[d][b-1] = 1'b1;
        else if (d == 0) exp_code[1] = 9'h100;
      end
    end
    // done cycle: start here must be ignored (R8)
    check(done_o == 1'b1 && short_o == 1'b0, "R7", {done_o, short_o}, 2'b10);
    check(dac_codes_o == {tb, ta}, "R7", dac_codes_o, {tb, ta});
    start_i   = 1'b1;
    cmp_pos_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b0, "R7", done_o, 0);
    check(short_o == 1'b0, "R8", short_o, 0);
    for (int i = 0; i < 5; i++) begin
      cmp_pos_i = ~cmp_pos_i;
      @(negedge clk);
      check(dac_codes_o == {tb, ta} && short_o == 1'b0, "R9", dac_codes_o, {tb, ta});
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    seed_sink = $urandom(32'h5A17_0C3E);
    rst_n     = 1'b0;
    start_i   = 1'b0;
    cmp_pos_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state under reset
    check(dac_codes_o == '0 && !short_o && !done_o && cal_sel_o == 1'b0, "R1",
          {short_o, done_o, dac_codes_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dac_codes_o == '0 && !short_o && !done_o, "R1", dac_codes_o, 0);

    run_cal(9'd0,   9'd511, 1'b1, -1);
    run_cal(9'd511, 9'd0,   1'b1, 40);
    run_cal(9'd256, 9'd255, 1'b1, 100);
    run_cal(9'd1,   9'd510, 1'b0, 143);
    for (int r = 0; r < 8; r++) begin
      logic [W-1:0] a, b;
      a = W'($urandom_range(0, 511));
      b = W'($urandom_range(0, 511));
      run_cal(a, b, 1'($urandom_range(0, 1)), int'($urandom_range(0, RUNL - 1)));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule